// File: doc/BRIEF.md
# Scanline interrupt down-counter

This block raises a scanline-timed interrupt request for a cartridge-side memory controller. The CPU programs it through four write registers: a reload value, an immediate reload strobe, an enable strobe and a disable/acknowledge strobe. The reload register keeps the one's complement of the byte the CPU writes. Once per scanline the video side sends a tick. The tick carries a flag saying whether the line lies in the visible area and a flag saying whether rendering is blanked on that line.

The 8-bit counter steps down by one on each visible tick. When a tick finds the counter at zero, the counter takes the reload value and does not decrement on that tick. When a decrement brings the counter to zero, the interrupt request is raised, provided interrupts are enabled and the line is not blanked. The request is a two-state machine. `IRQ_IDLE` goes to `IRQ_RAISED` on a qualified expiry (transition *fire*). `IRQ_RAISED` stays there (transition *hold*) until a disable/acknowledge write returns it to `IRQ_IDLE` (transition *ack*). An acknowledge write also moves `IRQ_IDLE` back to itself, and it has priority over a qualified expiry in the same cycle.

Top module: `scanirq_top`

## Requirements
- R1: After reset the interrupt output is low, interrupts are disabled, and both the counter and the reload value are zero. Enabling interrupts and sending visible ticks therefore raises nothing.
- R2: A write is decoded only when the address ANDed with 0x6003 equals 0x4000, 0x4001, 0x4002 or 0x4003. Address bits outside that mask are ignored, so 0x5004 acts as 0x4000. Writes to addresses such as 0x0001 or 0x6002 have no effect.
- R3: A write to register 0 (0x4000) stores the bitwise inverse of the data byte as the 8-bit reload value.
- R4: A write to register 1 (0x4001) copies the reload value into the counter. If a tick arrives in the same cycle, the write wins and the tick is dropped.
- R5: On a visible tick, a nonzero counter decrements by one. A zero counter is loaded with the reload value and does not decrement, so a nonzero reload value L fires every L+1 visible ticks.
- R6: The interrupt output goes high one clock after the visible tick whose decrement brings the counter to zero. This happens only if interrupts were enabled before that edge and the tick is not marked blanked.
- R7: Ticks marked not visible leave the counter unchanged.
- R8: A write to register 2 (0x4002) enables interrupts. A write to register 3 (0x4003) disables them and drops the interrupt output, and it wins over an expiry in the same cycle.
- R9: Once high, the interrupt output stays high through further ticks and reloads until a register 3 write.
- R10: A reload value of 0 (written data 0xFF) never raises the interrupt, because the counter is reloaded with zero on every visible tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 15 | CPU write address, offset within the upper program window |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| line_visible | input | 1 | Qualifies line_tick: the line is in the visible area |
| line_blanked | input | 1 | Qualifies line_tick: rendering is blanked on the line |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
All register writes and ticks take effect at the rising edge on which they are presented. The interrupt output changes at that same edge, so it is due one clock after the tick or acknowledge that causes it. The bench drives every stimulus on a falling edge and samples `irq_o` on the next falling edge, half a cycle after the edge that acts on the stimulus. For each reload value L, it checks that the output is still low after tick L-1 and high after tick L. It takes L from the inverse of the written byte, computed in the bench.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

    // Decoded CPU write operation
    typedef enum logic [2:0] {
        OP_NONE,
        OP_LATCH,
        OP_RELOAD,
        OP_ENABLE,
        OP_ACK
    } wr_op_e;

    // Interrupt request state
    typedef enum logic {
        IRQ_IDLE,
        IRQ_RAISED
    } irq_state_e;

endpackage

// File: rtl/scanirq_decode.sv
module scanirq_decode
    import scanirq_pkg::*;
#(
    parameter int                ADDR_W   = 15,
    parameter logic [ADDR_W-1:0] SEL_MASK = 15'h6003,
    parameter logic [ADDR_W-1:0] SEL_BASE = 15'h4000
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_op_e            op
);
    localparam int SUB_W = 2;

    logic             hit;
    logic [SUB_W-1:0] sub;

    assign sub = wr_addr[SUB_W-1:0];
    assign hit = wr_en &&
                 ((wr_addr & SEL_MASK & ~ADDR_W'((1 << SUB_W) - 1)) == SEL_BASE);

    always_comb begin
        op = OP_NONE;
        if (hit) begin
            unique case (sub)
                2'd0: op = OP_LATCH;
                2'd1: op = OP_RELOAD;
                2'd2: op = OP_ENABLE;
                2'd3: op = OP_ACK;
            endcase
        end
    end

endmodule

// File: rtl/scanirq_count.sv
module scanirq_count
    import scanirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_op_e           op,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             line_tick,
    input  logic             line_visible,
    output logic             expire,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    // A visible tick acts unless a reload write takes the cycle
    assign step   = line_tick && line_visible && (op != OP_RELOAD);
    assign expire = step && (cnt_q == ONE);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= ZERO;
        end else if (op == OP_LATCH) begin
            latch_q <= ~wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (op == OP_RELOAD) begin
            cnt_q <= latch_q;
        end else if (step) begin
            if (cnt_q != ZERO) cnt_q <= cnt_q - ONE;
            else               cnt_q <= latch_q;
        end
    end

    // R7
    offscreen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && !line_visible && op != OP_RELOAD) |=> $stable(cnt_q));

    // R5
    zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == ZERO && op != OP_LATCH) |=> (cnt_q == latch_q));

endmodule

// File: rtl/scanirq_top.sv
module scanirq_top
    import scanirq_pkg::*;
#(
    parameter int                ADDR_W   = 15,
    parameter int                CNT_W    = 8,
    parameter logic [ADDR_W-1:0] SEL_MASK = 15'h6003,
    parameter logic [ADDR_W-1:0] SEL_BASE = 15'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              line_tick,
    input  logic              line_visible,
    input  logic              line_blanked,
    output logic              irq_o
);
    wr_op_e           op;
    logic             expire;
    logic [CNT_W-1:0] cnt;
    logic             en_q;
    logic             fire;
    irq_state_e       state_q, state_d;

    scanirq_decode #(
        .ADDR_W  (ADDR_W),
        .SEL_MASK(SEL_MASK),
        .SEL_BASE(SEL_BASE)
    ) decode_i (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .op     (op)
    );

    scanirq_count #(
        .CNT_W(CNT_W)
    ) count_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .wr_data     (wr_data),
        .line_tick   (line_tick),
        .line_visible(line_visible),
        .expire      (expire),
        .cnt_o       (cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                en_q <= 1'b0;
        else if (op == OP_ENABLE)  en_q <= 1'b1;
        else if (op == OP_ACK)     en_q <= 1'b0;
    end

    assign fire = expire && en_q && !line_blanked;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (op != OP_ACK && fire) state_d = IRQ_RAISED;
            IRQ_RAISED: if (op == OP_ACK)         state_d = IRQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            IRQ_IDLE:   irq_o = 1'b0;
            IRQ_RAISED: irq_o = 1'b1;
        endcase
    end

    // R6
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(line_tick && line_visible && !line_blanked && en_q));

    // R6
    zero_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (cnt == '0));

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACK) |=> (!irq_o && !en_q));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && op != OP_ACK) |=> irq_o);

endmodule

// File: tb/scanirq_top_tb.sv
module scanirq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_tick = 1'b0;
    logic        line_visible = 1'b0;
    logic        line_blanked = 1'b0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanirq_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .line_tick   (line_tick),
        .line_visible(line_visible),
        .line_blanked(line_blanked),
        .irq_o       (irq_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: irq_o actual %b expected %b", req, act, exp);
        end
    endtask

    // One operation: drive on a falling edge, act on the rising edge, release
    // and leave the caller at the next falling edge, where irq_o is settled.
    task automatic cyc(input logic we, input logic [14:0] a, input logic [7:0] d,
                       input logic tk, input logic vis, input logic blk);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        line_tick = tk; line_visible = vis; line_blanked = blk;
        @(negedge clk);
        wr_en = 1'b0; line_tick = 1'b0; line_visible = 1'b0; line_blanked = 1'b0;
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic tick(input logic vis, input logic blk);
        cyc(1'b0, 15'h0, 8'h0, 1'b1, vis, blk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 reset irq low", irq_o, 1'b0);
        wr(15'h4002, 8'h00);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        check("R1 zero latch and counter, no irq", irq_o, 1'b0);
        wr(15'h4001, 8'h00);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        check("R1 reload of zero latch, no irq", irq_o, 1'b0);

        // R3 R5 R6 R10: sweep every written byte
        for (int d = 0; d < 256; d++) begin
            int lv;
            lv = (~d) & 8'hFF;
            wr(15'h4000, 8'(d));
            wr(15'h4001, 8'h00);
            wr(15'h4002, 8'h00);
            if (lv == 0) begin
                tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
                check("R10 zero reload never fires", irq_o, 1'b0);
            end else begin
                for (int t = 1; t < lv; t++) tick(1'b1, 1'b0);
                check("R3 R5 low before expiry", irq_o, 1'b0);
                tick(1'b1, 1'b0);
                check("R6 high on expiring tick", irq_o, 1'b1);
            end
            wr(15'h4003, 8'h00);
            check("R8 ack drops irq", irq_o, 1'b0);
        end

        // R5 R9: periodic refire with period L+1, hold through reload
        wr(15'h4000, 8'hFD);              // L = 2
        wr(15'h4001, 8'h00);
        wr(15'h4002, 8'h00);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        check("R6 fire L=2", irq_o, 1'b1);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        check("R9 held through reload and decrement", irq_o, 1'b1);
        wr(15'h4003, 8'h00);
        wr(15'h4002, 8'h00);
        tick(1'b1, 1'b0);                 // counter 1 -> 0 fires again
        check("R5 second period", irq_o, 1'b1);
        wr(15'h4003, 8'h00);
        wr(15'h4002, 8'h00);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        check("R5 zero reloads without decrement", irq_o, 1'b0);
        tick(1'b1, 1'b0);
        check("R5 period is L+1", irq_o, 1'b1);
        wr(15'h4003, 8'h00);

        // R7: invisible ticks freeze the counter
        wr(15'h4000, 8'hFC);              // L = 3
        wr(15'h4001, 8'h00);
        wr(15'h4002, 8'h00);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        for (int k = 0; k < 5; k++) tick(1'b0, 1'b0);
        check("R7 invisible ticks no expiry", irq_o, 1'b0);
        tick(1'b1, 1'b0);
        check("R7 count resumes", irq_o, 1'b1);
        wr(15'h4003, 8'h00);

        // R6: blanked expiry raises nothing
        wr(15'h4000, 8'hFD);              // L = 2
        wr(15'h4001, 8'h00);
        wr(15'h4002, 8'h00);
        tick(1'b1, 1'b0); tick(1'b1, 1'b1);
        check("R6 blanked expiry", irq_o, 1'b0);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        check("R6 after blank, mid count", irq_o, 1'b0);
        tick(1'b1, 1'b0);
        check("R6 fires after blanked period", irq_o, 1'b1);
        wr(15'h4003, 8'h00);

        // R8: disabled expiry, then enable
        wr(15'h4000, 8'hFE);              // L = 1
        wr(15'h4001, 8'h00);
        tick(1'b1, 1'b0);
        check("R8 disabled expiry", irq_o, 1'b0);
        wr(15'h4002, 8'h00);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        check("R8 enabled expiry", irq_o, 1'b1);
        // R8: ack wins over same-cycle expiry
        wr(15'h4003, 8'h00);
        wr(15'h4002, 8'h00);
        wr(15'h4001, 8'h00);
        cyc(1'b1, 15'h4003, 8'h00, 1'b1, 1'b1, 1'b0);
        check("R8 ack wins over expiry", irq_o, 1'b0);

        // R4: reload write beats a tick in the same cycle
        wr(15'h4000, 8'hFA);              // L = 5
        wr(15'h4001, 8'h00);
        wr(15'h4002, 8'h00);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        cyc(1'b1, 15'h4001, 8'h00, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) tick(1'b1, 1'b0);
        check("R4 reload restarted count", irq_o, 1'b0);
        tick(1'b1, 1'b0);
        check("R4 fire after full reload", irq_o, 1'b1);
        wr(15'h4003, 8'h00);

        // R2: address mirrors and ignored writes
        wr(15'h5004, 8'hFC);              // mirror of register 0, L = 3
        wr(15'h4001, 8'h00);
        wr(15'h0001, 8'h00);              // ignored
        wr(15'h4002, 8'h00);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        wr(15'h2001, 8'h00);              // ignored, would reload
        tick(1'b1, 1'b0);
        check("R2 mirror decode and ignored writes", irq_o, 1'b1);
        wr(15'h4003, 8'h00);
        wr(15'h4001, 8'h00);
        wr(15'h6002, 8'h00);              // ignored, would enable
        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b0);
        check("R2 unmatched enable ignored", irq_o, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule